// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models, in synthesizable logic, the target side of a three-wire serial EEPROM. A host selects the target, toggles a serial clock and shifts in a frame: a start bit, a two-bit opcode, an address and, for the writing commands, a data word. The block decodes the frame. It answers reads from its own storage array, which holds 64 words of 16 bits or 128 bytes, and it can stream on through the array. Commands that change storage pass to an internal program timer. That timer keeps the target busy for a set number of cycles and then commits the change.

The serial inputs are sampled by the system clock. A serial clock rise is a 0-to-1 change between two samples. The single data output comes with an enable, so it can drive a tri-state pad. The output carries read data, or the ready/busy state once a program cycle has been started.

Top module: `serial_eeprom_target`

## Requirements
- R1: A frame begins with the first serial clock rise that samples serIn=1 while chipSel is high. Rises that sample 0 before it are ignored. The next two bits are the opcode: 10 reads, 01 writes, 11 erases one location, and 00 selects a special command. For a special command, the two most significant address bits choose the action: 11 enables writing, 00 disables writing, 10 erases everything, and 01 writes one value everywhere.
- R2: With orgWide=1 the array is 64 words of 16 bits and the address is 6 bits. With orgWide=0 it is 128 bytes and the address is 7 bits. Byte address 2k is bits [7:0] of word k, and byte address 2k+1 is bits [15:8] of word k. Write data is 16 or 8 bits and is sent MSB first.
- R3: On the rise that samples the last address bit of a read, serOutEn goes high and serOut drives a 0 dummy bit. Each later rise presents the next bit of the addressed word, MSB first.
- R4: While chipSel stays high, the word after the last one follows at once, with no dummy bit, from address+1. After the top address the stream wraps to address 0.
- R5: After reset every location reads as all ones, writing is disabled, and serOutEn is low.
- R6: While writing is disabled, write, erase, erase-all and write-all change nothing and start no program cycle. Enable stays in force until a disable command. Reads work in both states.
- R7: A storage-changing command takes effect only when chipSel falls after its last bit. If chipSel falls earlier, the command is discarded.
- R8: Erase sets one word (or byte) to all ones. Erase-all sets every location to all ones. Write-all stores the data in every word, or in every byte in 8-bit mode.
- R9: Starting a program cycle arms the status output. While status is armed and chipSel is high, serOutEn is high, and serOut is 0 for PROG_CYCLES cycles and 1 afterwards. A rise with serIn=1 once the target is ready clears the status and sets serOutEn low. The same rise during busy is ignored.
- R10: While the program cycle runs, every frame is ignored.
- R11: While chipSel is low, serOutEn is low and any partly received frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| chipSel | input | 1 | Target select, active high |
| serClk | input | 1 | Serial clock, sampled by clk |
| serIn | input | 1 | Serial data in |
| orgWide | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| serOut | output | 1 | Serial data / status out |
| serOutEn | output | 1 | Drive enable for serOut |

## Verification
The bench builds the block with the default 64-by-16 array and a program time shortened to 40 cycles. With that setting the busy and ready phases of status polling can both be observed inside one short select window. The organisation input is switched at run time, so one build covers byte-address mapping and both wrap points of the sequential read. With only 64 words, every bulk command can be checked by reading back a few locations.

// File: rtl/serial_eeprom_target_pkg.sv
package serial_eeprom_target_pkg;

  typedef enum logic [2:0] {
    PG_NONE  = 3'd0,
    PG_WRITE = 3'd1,
    PG_ERASE = 3'd2,
    PG_ERAL  = 3'd3,
    PG_WRAL  = 3'd4
  } progOp_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HDR  = 3'd1,
    S_DATA = 3'd2,
    S_READ = 3'd3,
    S_HOLD = 3'd4
  } frameSt_e;

  typedef struct packed {
    logic    shiftHdr;
    logic    shiftData;
    logic    loadRead;
    logic    stepRead;
    logic    progReq;
    progOp_e progOp;
  } mwStrobe_t;

endpackage

// File: rtl/serial_eeprom_target_ctrl.sv
module serial_eeprom_target_ctrl
  import serial_eeprom_target_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      chipSel,
  input  logic      serClk,
  input  logic      serIn,
  input  logic      orgWide,
  input  logic      busy,
  input  logic [1:0] opNext,
  input  logic [1:0] subNext,
  output mwStrobe_t stb,
  output logic      statusArm,
  output logic      readDrive,
  output logic      wenFlag
);
  localparam int CNT_W = $clog2(WIDTH + ADDR_W + 4);

  frameSt_e state, stateN;
  progOp_e  pend, pendN;
  logic [CNT_W-1:0] cnt, cntN;
  logic armN, wenN;
  logic skPrev, csPrev;
  logic skRise, csFall;
  logic [CNT_W-1:0] hdrLast, dataLast;

  assign skRise   = chipSel & serClk & ~skPrev;
  assign csFall   = csPrev & ~chipSel;
  assign hdrLast  = orgWide ? CNT_W'(ADDR_W + 1) : CNT_W'(ADDR_W + 2);
  assign dataLast = orgWide ? CNT_W'(WIDTH - 1) : CNT_W'(WIDTH / 2 - 1);
  assign readDrive = (state == S_READ);

  always_comb begin
    stateN = state;
    cntN   = cnt;
    pendN  = pend;
    armN   = statusArm;
    wenN   = wenFlag;
    stb    = '0;
    if (!chipSel) begin
      stateN = S_IDLE;
      cntN   = '0;
      pendN  = PG_NONE;
      if (csFall && state == S_HOLD && pend != PG_NONE) begin
        stb.progReq = 1'b1;
        stb.progOp  = pend;
        armN        = 1'b1;
      end
    end else if (skRise) begin
      case (state)
        S_IDLE: begin
          if (!busy && serIn) begin
            if (statusArm) armN = 1'b0;
            else begin
              stateN = S_HDR;
              cntN   = '0;
            end
          end
        end
        S_HDR: begin
          stb.shiftHdr = 1'b1;
          cntN = cnt + 1'b1;
          if (cnt == hdrLast) begin
            cntN   = '0;
            stateN = S_HOLD;
            case (opNext)
              2'b10: begin
                stb.loadRead = 1'b1;
                stateN = S_READ;
              end
              2'b01: if (wenFlag) begin
                pendN  = PG_WRITE;
                stateN = S_DATA;
              end
              2'b11: if (wenFlag) pendN = PG_ERASE;
              default: begin
                case (subNext)
                  2'b11: wenN = 1'b1;
                  2'b00: wenN = 1'b0;
                  2'b10: if (wenFlag) pendN = PG_ERAL;
                  default: if (wenFlag) begin
                    pendN  = PG_WRAL;
                    stateN = S_DATA;
                  end
                endcase
              end
            endcase
          end
        end
        S_DATA: begin
          stb.shiftData = 1'b1;
          cntN = cnt + 1'b1;
          if (cnt == dataLast) begin
            cntN   = '0;
            stateN = S_HOLD;
          end
        end
        S_READ: stb.stepRead = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      pend      <= PG_NONE;
      statusArm <= 1'b0;
      wenFlag   <= 1'b0;
      skPrev    <= 1'b0;
      csPrev    <= 1'b0;
    end else begin
      state     <= stateN;
      cnt       <= cntN;
      pend      <= pendN;
      statusArm <= armN;
      wenFlag   <= wenN;
      skPrev    <= serClk;
      csPrev    <= chipSel;
    end
  end

endmodule

// File: rtl/serial_eeprom_target_datapath.sv
module serial_eeprom_target_datapath
  import serial_eeprom_target_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       orgWide,
  input  logic       serIn,
  input  mwStrobe_t  stb,
  input  logic       commit,
  output logic [1:0] opNext,
  output logic [1:0] subNext,
  output logic       rdBit
);
  localparam int ADDR_W  = $clog2(WORDS);
  localparam int BADDR_W = ADDR_W + 1;
  localparam int HALF    = WIDTH / 2;
  localparam int HDR_W   = BADDR_W + 2;
  localparam int BIT_W   = $clog2(WIDTH);

  logic [WIDTH-1:0]   mem [WORDS];
  logic [HDR_W-1:0]   hdrSh, hdrNext;
  logic [BADDR_W-1:0] addrNext, cmdAddr, rdPtr;
  logic [WIDTH-1:0]   dataSh;
  progOp_e            pOp;
  logic               pOrg;
  logic [BIT_W-1:0]   bitIdx, topBit;
  logic [ADDR_W-1:0]  progIx, rdIx, wIncr;
  logic [WIDTH-1:0]   rdWord, rdData, fillVal;

  assign hdrNext  = {hdrSh[HDR_W-2:0], serIn};
  assign addrNext = orgWide ? BADDR_W'(hdrNext[ADDR_W-1:0]) : hdrNext[BADDR_W-1:0];
  assign opNext   = orgWide ? hdrNext[ADDR_W+1:ADDR_W] : hdrNext[BADDR_W+1:BADDR_W];
  assign subNext  = orgWide ? hdrNext[ADDR_W-1:ADDR_W-2] : hdrNext[BADDR_W-1:BADDR_W-2];

  assign progIx  = pOrg ? cmdAddr[ADDR_W-1:0] : cmdAddr[BADDR_W-1:1];
  assign fillVal = (pOp == PG_WRITE || pOp == PG_WRAL) ? dataSh : '1;

  assign rdIx   = orgWide ? rdPtr[ADDR_W-1:0] : rdPtr[BADDR_W-1:1];
  assign rdWord = mem[rdIx];
  assign rdData = orgWide ? rdWord :
                  (rdPtr[0] ? WIDTH'(rdWord[WIDTH-1:HALF]) : WIDTH'(rdWord[HALF-1:0]));
  assign topBit = orgWide ? BIT_W'(WIDTH - 1) : BIT_W'(HALF - 1);
  assign wIncr  = rdPtr[ADDR_W-1:0] + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrSh   <= '0;
      cmdAddr <= '0;
      dataSh  <= '0;
      pOp     <= PG_NONE;
      pOrg    <= 1'b1;
    end else begin
      if (stb.shiftHdr) begin
        hdrSh   <= hdrNext;
        cmdAddr <= addrNext;
      end
      if (stb.shiftData) dataSh <= {dataSh[WIDTH-2:0], serIn};
      if (stb.progReq) begin
        pOp  <= stb.progOp;
        pOrg <= orgWide;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      case (pOp)
        PG_WRITE, PG_ERASE: begin
          if (pOrg) mem[progIx] <= fillVal;
          else if (cmdAddr[0]) mem[progIx][WIDTH-1:HALF] <= fillVal[HALF-1:0];
          else mem[progIx][HALF-1:0] <= fillVal[HALF-1:0];
        end
        PG_ERAL: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        PG_WRAL: for (int i = 0; i < WORDS; i++)
          mem[i] <= pOrg ? dataSh : {2{dataSh[HALF-1:0]}};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBit  <= 1'b0;
      rdPtr  <= '0;
      bitIdx <= '0;
    end else if (stb.loadRead) begin
      rdBit  <= 1'b0;
      rdPtr  <= addrNext;
      bitIdx <= topBit;
    end else if (stb.stepRead) begin
      rdBit <= rdData[bitIdx];
      if (bitIdx == '0) begin
        bitIdx <= topBit;
        rdPtr  <= orgWide ? {1'b0, wIncr} : rdPtr + 1'b1;
      end else begin
        bitIdx <= bitIdx - 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_eeprom_target_progtimer.sv
module serial_eeprom_target_progtimer #(
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] remain;

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      remain <= CW'(PROG_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/serial_eeprom_target.sv
module serial_eeprom_target
  import serial_eeprom_target_pkg::*;
#(
  parameter int WORDS       = 64,
  parameter int WIDTH       = 16,
  parameter int PROG_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSel,
  input  logic serClk,
  input  logic serIn,
  input  logic orgWide,
  output logic serOut,
  output logic serOutEn
);
  localparam int ADDR_W = $clog2(WORDS);

  mwStrobe_t  stb;
  logic [1:0] opNext, subNext;
  logic       statusArm, readDrive, wenFlag;
  logic       busy, commit, rdBit, progReq;

  assign progReq  = stb.progReq;
  assign serOutEn = chipSel & (statusArm | readDrive);
  assign serOut   = serOutEn & (statusArm ? ~busy : rdBit);

  serial_eeprom_target_ctrl #(.ADDR_W(ADDR_W), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .orgWide(orgWide), .busy(busy), .opNext(opNext), .subNext(subNext),
    .stb(stb), .statusArm(statusArm), .readDrive(readDrive), .wenFlag(wenFlag)
  );

  serial_eeprom_target_datapath #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .orgWide(orgWide), .serIn(serIn), .stb(stb),
    .commit(commit), .opNext(opNext), .subNext(subNext), .rdBit(rdBit)
  );

  serial_eeprom_target_progtimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .start(progReq), .busy(busy), .done(commit)
  );

endmodule

// File: rtl/serial_eeprom_target_chk.sv
module serial_eeprom_target_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rstN,
  input logic chipSel,
  input logic serOut,
  input logic serOutEn,
  input logic busy,
  input logic wenFlag,
  input logic progReq
);
  int unsigned busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else busyLen <= 0;
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |-> !serOutEn); // R11
  AST_BUSY_READS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (busy && serOutEn) |-> !serOut); // R9
  AST_REQ_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> wenFlag); // R6
  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    progReq |-> !busy); // R10
  AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(progReq)); // R7
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busyLen <= PROG_CYCLES); // R9

endmodule

bind serial_eeprom_target serial_eeprom_target_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .chipSel(chipSel), .serOut(serOut),
  .serOutEn(serOutEn), .busy(busy), .wenFlag(wenFlag), .progReq(progReq)
);

// File: tb/serial_eeprom_target_tb.sv
module serial_eeprom_target_tb;
  localparam int PROG = 40;
  localparam logic [23:0] VEC [6] = '{
    {1'b1, 7'h00, 16'hA55A},
    {1'b1, 7'h3F, 16'h1234},
    {1'b1, 7'h15, 16'h8001},
    {1'b0, 7'h10, 16'h00C3},
    {1'b0, 7'h11, 16'h003C},
    {1'b0, 7'h7F, 16'h005E}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSel = 1'b0, serClk = 1'b0, serIn = 1'b0, orgWide = 1'b1;
  logic serOut, serOutEn;
  int errors = 0, checks = 0;
  bit finished = 1'b0;
  logic [15:0] got [4];
  logic dummyOk;

  always #5 clk = ~clk;

  serial_eeprom_target #(.WORDS(64), .WIDTH(16), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .serClk(serClk), .serIn(serIn),
    .orgWide(orgWide), .serOut(serOut), .serOutEn(serOutEn)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic skBit(input logic b);
    serIn = b; tick(2); serClk = 1'b1; tick(2); serClk = 1'b0;
  endtask

  task automatic csOn();
    chipSel = 1'b1; tick(2);
  endtask

  task automatic csOff();
    chipSel = 1'b0; serClk = 1'b0; serIn = 1'b0; tick(3);
  endtask

  task automatic sendHdr(input logic [1:0] op, input logic [6:0] addr);
    int aw;
    aw = orgWide ? 6 : 7;
    skBit(1'b1); skBit(op[1]); skBit(op[0]);
    for (int i = aw - 1; i >= 0; i--) skBit(addr[i]);
  endtask

  task automatic readWords(input logic [6:0] addr, input int n);
    logic [15:0] v;
    int w;
    w = orgWide ? 16 : 8;
    csOn();
    sendHdr(2'b10, addr);
    dummyOk = (serOutEn === 1'b1) && (serOut === 1'b0);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int b = 0; b < w; b++) begin
        skBit(1'b0);
        v = {v[14:0], serOut};
      end
      got[k] = v;
    end
    csOff();
  endtask

  task automatic progCmd(input logic [1:0] op, input logic [6:0] addr,
                         input logic [15:0] data, input bit hasData);
    int w;
    w = orgWide ? 16 : 8;
    csOn();
    sendHdr(op, addr);
    if (hasData) for (int b = w - 1; b >= 0; b--) skBit(data[b]);
    csOff();
  endtask

  task automatic waitReady();
    csOn();
    for (int i = 0; i < PROG + 60; i++) begin
      if (serOut === 1'b1) break;
      tick(1);
    end
    chk("R9 ready level", {15'd0, serOut}, 16'd1);
    skBit(1'b1);
    csOff();
  endtask

  task automatic special(input logic [1:0] sub, input logic [15:0] data, input bit hasData);
    progCmd(2'b00, orgWide ? {1'b0, sub, 4'd0} : {sub, 5'd0}, data, hasData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(5); rstN = 1'b1; tick(2);
    chk("R5 oe after reset", {15'd0, serOutEn}, 16'd0);
    csOn();
    chk("R5 oe selected idle", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'd5, 1);
    chk("R5 erased content", got[0], 16'hFFFF);
    chk("R3 dummy zero", {15'd0, dummyOk}, 16'd1);

    // R6: write while disabled is ignored
    progCmd(2'b01, 7'd5, 16'h1234, 1'b1);
    csOn();
    chk("R6 no cycle when disabled", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'd5, 1);
    chk("R6 data kept when disabled", got[0], 16'hFFFF);

    special(2'b11, 16'h0, 1'b0);

    // table of writes and read-backs (R2, R3)
    for (int t = 0; t < 6; t++) begin
      orgWide = VEC[t][23];
      progCmd(2'b01, VEC[t][22:16], VEC[t][15:0], 1'b1);
      waitReady();
      readWords(VEC[t][22:16], 1);
      chk("R2 table read-back", got[0], VEC[t][15:0]);
      chk("R3 table dummy", {15'd0, dummyOk}, 16'd1);
    end

    orgWide = 1'b1;
    readWords(7'd8, 1);
    chk("R2 byte placement", got[0], 16'h3CC3);
    readWords(7'd63, 2);
    chk("R4 top word", got[0], 16'h5E34);
    chk("R4 wrap to word 0", got[1], 16'hA55A);
    orgWide = 1'b0;
    readWords(7'd127, 2);
    chk("R4 top byte", got[0], 16'h005E);
    chk("R4 byte wrap", got[1], 16'h005A);
    orgWide = 1'b1;

    // R9 status polling around an erase
    progCmd(2'b11, 7'h15, 16'h0, 1'b0);
    csOn();
    chk("R9 busy drives low", {14'd0, serOutEn, serOut}, 16'd2);
    skBit(1'b1);
    chk("R9 release ignored while busy", {15'd0, serOutEn}, 16'd1);
    tick(PROG + 10);
    chk("R9 ready drives high", {14'd0, serOutEn, serOut}, 16'd3);
    skBit(1'b1);
    chk("R9 dummy one releases", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'h15, 1);
    chk("R8 erase one word", got[0], 16'hFFFF);

    // R10 frames ignored while busy
    progCmd(2'b01, 7'd2, 16'hBEEF, 1'b1);
    csOn();
    skBit(1'b1); skBit(1'b1); skBit(1'b0);
    chk("R10 status not read data", {14'd0, serOutEn, serOut}, 16'd2);
    csOff();
    waitReady();
    readWords(7'd2, 1);
    chk("R10 pending write completed", got[0], 16'hBEEF);

    // R7 truncated write
    csOn();
    sendHdr(2'b01, 7'd0);
    for (int b = 0; b < 8; b++) skBit(1'b0);
    csOff();
    csOn();
    chk("R7 no cycle after truncation", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'd0, 1);
    chk("R7 truncated write discarded", got[0], 16'hA55A);

    // R11 select drop mid-read
    csOn();
    sendHdr(2'b10, 7'd1);
    skBit(1'b0); skBit(1'b0); skBit(1'b0);
    chipSel = 1'b0; tick(1);
    chk("R11 oe low when deselected", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'd0, 1);
    chk("R11 fresh frame after drop", got[0], 16'hA55A);

    // R6 disable then write
    special(2'b00, 16'h0, 1'b0);
    progCmd(2'b01, 7'd0, 16'h0000, 1'b1);
    csOn();
    chk("R6 disabled no status", {15'd0, serOutEn}, 16'd0);
    csOff();
    readWords(7'd0, 1);
    chk("R6 disabled write ignored", got[0], 16'hA55A);

    // R8 bulk commands
    special(2'b11, 16'h0, 1'b0);
    special(2'b10, 16'h0, 1'b0);
    waitReady();
    readWords(7'd63, 1);
    chk("R8 erase all top", got[0], 16'hFFFF);
    readWords(7'd0, 1);
    chk("R8 erase all bottom", got[0], 16'hFFFF);
    special(2'b01, 16'h0F0F, 1'b1);
    waitReady();
    readWords(7'd7, 1);
    chk("R8 write all words", got[0], 16'h0F0F);
    orgWide = 1'b0;
    special(2'b01, 16'h0066, 1'b1);
    waitReady();
    orgWide = 1'b1;
    readWords(7'd40, 1);
    chk("R8 write all bytes", got[0], 16'h6666);

    // R1 leading zeros before start bit
    csOn();
    skBit(1'b0); skBit(1'b0);
    sendHdr(2'b10, 7'd9);
    chk("R1 start after zeros", {14'd0, serOutEn, serOut}, 16'd2);
    for (int b = 0; b < 16; b++) skBit(1'b0);
    csOff();
    readWords(7'd9, 1);
    chk("R1 read value", got[0], 16'h6666);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule